// File: doc/BRIEF.md
# Outstanding-Request Watchdog

This block watches a class of flagged transmit requests (for example management packets) that are expected to leave the send queue within a bounded time. Each enqueue strobe marks one more flagged request in flight and each dequeue strobe marks one retired. A bulk-flush strobe retires all of them at once, as happens when the send path is aborted or shut down. The block keeps the number in flight on `count_o`.

A single countdown supervises progress. It starts when the first flagged request enters an empty set. It starts over with a full interval whenever a request retires and others remain. It stops without comment once nothing is outstanding. If the countdown runs out while work is still pending, `timeout_o` pulses for one cycle. The surrounding logic uses that pulse to cancel sends and block the head of the line.

The interval comes either from the `interval_i` port or, in the fixed variant, from a rate parameter. In the fixed variant it is one twentieth of the tick rate, rounded up.

Top module: `flag_req_watchdog`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `count_o` is 0 and `armed_o`, `timeout_o` and `underflow_o` are all 0.
- R2: An enqueue alone, with `count_o` at 0, sets `count_o` to 1 and loads the countdown with a full interval N. If the enqueue is sampled at edge 0 and nothing else happens, `armed_o` stays 1 through edge N-1. At edge N, `armed_o` falls and `timeout_o` rises for exactly one cycle.
- R3: An enqueue alone, with `count_o` already nonzero, increments the count and leaves the running countdown untouched, so the expiry edge does not move.
- R4: A dequeue alone that leaves `count_o` nonzero decrements it and reloads a full interval: expiry then falls N edges after the dequeue edge.
- R5: A dequeue alone that takes `count_o` from 1 to 0 clears `armed_o` at that edge, and no `timeout_o` pulse follows.
- R6: Enqueue and dequeue in the same cycle leave `count_o` unchanged. They reload a full interval if the count is nonzero, and have no effect at all (no arming, no underflow) if it is 0.
- R7: Flush has priority over every other input. It sets `count_o` to 0 and clears `armed_o` at that edge, no pulse follows, and `underflow_o` keeps its value.
- R8: The count saturates at 2^CNT_W-1 (63 by default): a further enqueue leaves it there.
- R9: A dequeue alone at count 0 leaves the count at 0 and sets `underflow_o`, which then stays 1 until reset.
- R10: After a timeout pulse the countdown stays idle while the count stays nonzero. A later enqueue does not re-arm it. The next dequeue that leaves work pending, or the next enqueue into an empty set, does re-arm it.
- R11: An `interval_i` of 0 acts as 1. The interval is captured when the countdown is loaded, so later changes to `interval_i` do not move a running expiry.
- R12: With FIXED_IVL=1 the interval is ceil(TICK_HZ/20) cycles (51 for TICK_HZ=1010) and `interval_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enq_i | input | 1 | One flagged request entered the queue this cycle |
| deq_i | input | 1 | One flagged request retired this cycle |
| flush_i | input | 1 | All flagged requests retired at once |
| interval_i | input | IVL_W | Countdown length in cycles (port variant) |
| count_o | output | CNT_W | Flagged requests outstanding |
| armed_o | output | 1 | Countdown running |
| timeout_o | output | 1 | One-cycle pulse: countdown expired with work pending |
| underflow_o | output | 1 | Sticky: a dequeue arrived with nothing outstanding |

## Verification
The assertions assume that reset is held low for at least one edge before any strobe is given and that the strobes carry known values at every edge. The one-step bound on the count also assumes that enqueue and dequeue describe at most one request each per cycle. The bench drives each strobe for exactly one edge, one nanosecond after a rising edge, and holds the interval steady except in the test that changes it on purpose while the countdown runs. It also exercises dequeue at zero, but only once, near the end of the run, so that the sticky flag does not hide the earlier checks.

// File: rtl/wd_pkg.sv
package wd_pkg;
   typedef enum logic [1:0] {
      TMR_HOLD = 2'd0,
      TMR_LOAD = 2'd1,
      TMR_STOP = 2'd2
   } tmr_cmd_e;

   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction
endpackage

// File: rtl/wd_occupancy.sv
module wd_occupancy
   import wd_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enq_i,
   input  logic             deq_i,
   input  logic             flush_i,
   output logic [CNT_W-1:0] cnt_o,
   output tmr_cmd_e         cmd_o,
   output logic             unf_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   generate
      if (CNT_W < 1 || CNT_W > 30) begin : g_bad_cnt_w
         $error("wd_occupancy: CNT_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             unf_q, unf_d;

   always_comb begin
      cnt_d = cnt_q;
      unf_d = unf_q;
      cmd_o = TMR_HOLD;
      if (flush_i) begin
         cnt_d = '0;
         cmd_o = TMR_STOP;
      end else if (enq_i && deq_i) begin
         if (cnt_q != '0) cmd_o = TMR_LOAD;
      end else if (enq_i) begin
         if (cnt_q == '0) begin
            cnt_d = CNT_ONE;
            cmd_o = TMR_LOAD;
         end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + CNT_ONE;
         end
      end else if (deq_i) begin
         if (cnt_q == '0) begin
            unf_d = 1'b1;
         end else begin
            cnt_d = cnt_q - CNT_ONE;
            cmd_o = (cnt_q == CNT_ONE) ? TMR_STOP : TMR_LOAD;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         unf_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         unf_q <= unf_d;
      end
   end

   assign cnt_o = cnt_q;
   assign unf_o = unf_q;

   a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (cnt_q == '0));
   a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      unf_q |=> unf_q);
   a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX && enq_i && !deq_i && !flush_i) |=> (cnt_q == CNT_MAX));
   a_r6_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      !flush_i |=> (int'(cnt_q) == int'($past(cnt_q)) ||
                    int'(cnt_q) == int'($past(cnt_q)) + 1 ||
                    int'(cnt_q) + 1 == int'($past(cnt_q))));
endmodule

// File: rtl/wd_interval_sel.sv
module wd_interval_sel #(
   parameter int          IVL_W     = 20,
   parameter bit          FIXED_IVL = 1'b0,
   parameter int unsigned TICK_HZ   = 1010
) (
   input  logic [IVL_W-1:0] ivl_i,
   output logic [IVL_W-1:0] load_o
);
   localparam int unsigned NOMINAL = wd_pkg::ceil_div(TICK_HZ, 20);

   generate
      if (IVL_W < 2 || IVL_W > 30) begin : g_bad_ivl_w
         $error("wd_interval_sel: IVL_W out of range");
      end
      if (NOMINAL < 1 || NOMINAL >= (1 << IVL_W)) begin : g_bad_nominal
         $error("wd_interval_sel: nominal interval does not fit IVL_W");
      end

      if (FIXED_IVL) begin : g_fixed
         logic ivl_unused;
         assign ivl_unused = ^ivl_i;
         assign load_o     = IVL_W'(NOMINAL);
      end else begin : g_port
         assign load_o = (ivl_i == '0) ? IVL_W'(1) : ivl_i;
      end
   endgenerate
endmodule

// File: rtl/wd_countdown.sv
module wd_countdown
   import wd_pkg::*;
#(
   parameter int IVL_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tmr_cmd_e         cmd_i,
   input  logic [IVL_W-1:0] load_i,
   output logic             armed_o,
   output logic             expire_o
);
   localparam logic [IVL_W-1:0] REM_ONE = IVL_W'(1);

   logic [IVL_W-1:0] rem_q;
   logic             armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         rem_q   <= '0;
      end else begin
         unique case (cmd_i)
            TMR_LOAD: begin
               armed_q <= 1'b1;
               rem_q   <= load_i;
            end
            TMR_STOP: begin
               armed_q <= 1'b0;
               rem_q   <= '0;
            end
            default: begin
               if (armed_q) begin
                  if (rem_q == REM_ONE) begin
                     armed_q <= 1'b0;
                     rem_q   <= '0;
                  end else begin
                     rem_q <= rem_q - REM_ONE;
                  end
               end
            end
         endcase
      end
   end

   assign armed_o  = armed_q;
   assign expire_o = (cmd_i == TMR_HOLD) && armed_q && (rem_q == REM_ONE);

   a_r2_load_full: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == TMR_LOAD) |=> (armed_q && rem_q == $past(load_i)));
   a_r5_stop_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == TMR_STOP) |=> !armed_q);
   a_r11_rem_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (rem_q != '0));
endmodule

// File: rtl/flag_req_watchdog.sv
module flag_req_watchdog
   import wd_pkg::*;
#(
   parameter int          CNT_W     = 6,
   parameter int          IVL_W     = 20,
   parameter bit          FIXED_IVL = 1'b0,
   parameter int unsigned TICK_HZ   = 1010
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enq_i,
   input  logic             deq_i,
   input  logic             flush_i,
   input  logic [IVL_W-1:0] interval_i,
   output logic [CNT_W-1:0] count_o,
   output logic             armed_o,
   output logic             timeout_o,
   output logic             underflow_o
);
   tmr_cmd_e         tmr_cmd;
   logic [IVL_W-1:0] load_val;
   logic             expire;
   logic             timeout_q;

   wd_occupancy #(.CNT_W(CNT_W)) u_occ (
      .clk     (clk),
      .rst_n   (rst_n),
      .enq_i   (enq_i),
      .deq_i   (deq_i),
      .flush_i (flush_i),
      .cnt_o   (count_o),
      .cmd_o   (tmr_cmd),
      .unf_o   (underflow_o)
   );

   wd_interval_sel #(.IVL_W(IVL_W), .FIXED_IVL(FIXED_IVL), .TICK_HZ(TICK_HZ)) u_ivl (
      .ivl_i  (interval_i),
      .load_o (load_val)
   );

   wd_countdown #(.IVL_W(IVL_W)) u_cd (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_i    (tmr_cmd),
      .load_i   (load_val),
      .armed_o  (armed_o),
      .expire_o (expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) timeout_q <= 1'b0;
      else        timeout_q <= expire && (count_o != '0);
   end

   assign timeout_o = timeout_q;

   a_r10_armed_has_work: assert property (@(posedge clk) disable iff (!rst_n)
      armed_o |-> (count_o != '0));
   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |=> !timeout_o);
   a_r10_pulse_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> !armed_o);
   a_r7_flush_quiets: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (!armed_o && !timeout_o && count_o == '0));
endmodule

// File: tb/flag_req_watchdog_bench.sv
module flag_req_watchdog_bench;
   localparam int CNT_W = 6;
   localparam int IVL_W = 20;
   localparam int N     = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enq = 1'b0, deq = 1'b0, flush = 1'b0;
   logic [IVL_W-1:0] ivl = IVL_W'(N);
   logic [CNT_W-1:0] count;
   logic armed, timeout, unf;

   logic f_enq = 1'b0, f_flush = 1'b0;
   logic [CNT_W-1:0] f_count;
   logic f_armed, f_timeout, f_unf;

   int n_checks = 0;
   int n_fail   = 0;
   int n_pulse  = 0;

   always #2 clk = ~clk;

   flag_req_watchdog #(.CNT_W(CNT_W), .IVL_W(IVL_W)) u_flag_req_watchdog (
      .clk(clk), .rst_n(rst_n), .enq_i(enq), .deq_i(deq), .flush_i(flush),
      .interval_i(ivl), .count_o(count), .armed_o(armed), .timeout_o(timeout),
      .underflow_o(unf));

   flag_req_watchdog #(.CNT_W(CNT_W), .IVL_W(IVL_W), .FIXED_IVL(1'b1), .TICK_HZ(1010))
   u_flag_req_watchdog_fixed (
      .clk(clk), .rst_n(rst_n), .enq_i(f_enq), .deq_i(1'b0), .flush_i(f_flush),
      .interval_i(IVL_W'(3)), .count_o(f_count), .armed_o(f_armed), .timeout_o(f_timeout),
      .underflow_o(f_unf));

   always @(posedge clk) if (rst_n && timeout) n_pulse++;

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic drive(input logic e, input logic d, input logic f);
      enq = e; deq = d; flush = f;
      @(posedge clk); #1;
      enq = 1'b0; deq = 1'b0; flush = 1'b0;
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
   endtask

   task automatic t_reset;
      chk("R1 count in reset", int'(count), 0);
      chk("R1 armed in reset", int'(armed), 0);
      rst_n = 1'b1;
      wait_cyc(1);
      chk("R1 count", int'(count), 0);
      chk("R1 armed", int'(armed), 0);
      chk("R1 timeout", int'(timeout), 0);
      chk("R1 underflow", int'(unf), 0);
   endtask

   task automatic t_arm_expire;
      int base;
      drive(1, 0, 0);
      chk("R2 count after first enq", int'(count), 1);
      chk("R2 armed after first enq", int'(armed), 1);
      wait_cyc(N - 1);
      chk("R2 no pulse before edge N", int'(timeout), 0);
      chk("R2 still armed at edge N-1", int'(armed), 1);
      wait_cyc(1);
      chk("R2 pulse at edge N", int'(timeout), 1);
      chk("R2 disarmed at edge N", int'(armed), 0);
      chk("R10 count kept after pulse", int'(count), 1);
      wait_cyc(1);
      chk("R2 pulse one cycle", int'(timeout), 0);
      base = n_pulse;
      drive(1, 0, 0);
      chk("R10 enq after pulse count", int'(count), 2);
      chk("R10 enq after pulse no arm", int'(armed), 0);
      wait_cyc(2 * N);
      chk("R10 no pulse while idle", n_pulse - base, 0);
      drive(0, 1, 0);
      chk("R10 deq re-arms", int'(armed), 1);
      chk("R10 deq count", int'(count), 1);
      drive(0, 0, 1);
      chk("R7 flush count", int'(count), 0);
      chk("R7 flush armed", int'(armed), 0);
   endtask

   task automatic t_no_restart;
      drive(1, 0, 0);
      wait_cyc(3);
      drive(1, 0, 0);
      chk("R3 second enq count", int'(count), 2);
      wait_cyc(3);
      chk("R3 no pulse at edge 7", int'(timeout), 0);
      wait_cyc(1);
      chk("R3 pulse at original edge 8", int'(timeout), 1);
      drive(0, 0, 1);
   endtask

   task automatic t_reload;
      drive(1, 0, 0);
      drive(1, 0, 0);
      wait_cyc(2);
      drive(0, 1, 0);
      chk("R4 count after deq", int'(count), 1);
      wait_cyc(N - 1);
      chk("R4 no pulse before reload end", int'(timeout), 0);
      chk("R4 armed before reload end", int'(armed), 1);
      wait_cyc(1);
      chk("R4 pulse N after deq", int'(timeout), 1);
      drive(0, 0, 1);
   endtask

   task automatic t_deq_zero;
      int base;
      base = n_pulse;
      drive(1, 0, 0);
      wait_cyc(2);
      drive(0, 1, 0);
      chk("R5 count zero", int'(count), 0);
      chk("R5 disarmed", int'(armed), 0);
      wait_cyc(2 * N);
      chk("R5 no pulse", n_pulse - base, 0);
      chk("R5 no underflow", int'(unf), 0);
   endtask

   task automatic t_both;
      drive(1, 1, 0);
      chk("R6 pair at zero count", int'(count), 0);
      chk("R6 pair at zero armed", int'(armed), 0);
      chk("R6 pair at zero underflow", int'(unf), 0);
      drive(1, 0, 0);
      wait_cyc(3);
      drive(1, 1, 0);
      chk("R6 pair count unchanged", int'(count), 1);
      wait_cyc(N - 1);
      chk("R6 no pulse before reload end", int'(timeout), 0);
      wait_cyc(1);
      chk("R6 pulse N after pair", int'(timeout), 1);
      drive(0, 0, 1);
   endtask

   task automatic t_flush;
      int base;
      drive(1, 0, 0);
      drive(1, 0, 0);
      drive(1, 0, 0);
      base = n_pulse;
      drive(0, 0, 1);
      chk("R7 flush count", int'(count), 0);
      chk("R7 flush armed", int'(armed), 0);
      wait_cyc(2 * N);
      chk("R7 no pulse after flush", n_pulse - base, 0);
      drive(1, 0, 1);
      chk("R7 flush beats enq", int'(count), 0);
      chk("R7 flush beats enq armed", int'(armed), 0);
   endtask

   task automatic t_sat;
      for (int i = 0; i < 64; i++) drive(1, 0, 0);
      chk("R8 saturated", int'(count), 63);
      drive(1, 0, 0);
      chk("R8 stays saturated", int'(count), 63);
      drive(0, 1, 0);
      chk("R8 deq from max", int'(count), 62);
      drive(0, 0, 1);
   endtask

   task automatic t_interval;
      ivl = '0;
      drive(1, 0, 0);
      chk("R11 zero interval armed", int'(armed), 1);
      wait_cyc(1);
      chk("R11 zero interval acts as one", int'(timeout), 1);
      drive(0, 0, 1);
      ivl = IVL_W'(5);
      drive(1, 0, 0);
      ivl = IVL_W'(20);
      wait_cyc(4);
      chk("R11 no pulse at edge 4", int'(timeout), 0);
      wait_cyc(1);
      chk("R11 captured interval used", int'(timeout), 1);
      drive(0, 0, 1);
      ivl = IVL_W'(N);
   endtask

   task automatic t_underflow;
      drive(0, 1, 0);
      chk("R9 count stays zero", int'(count), 0);
      chk("R9 underflow set", int'(unf), 1);
      drive(1, 0, 0);
      chk("R9 enq still works", int'(count), 1);
      chk("R9 underflow sticky", int'(unf), 1);
      drive(0, 0, 1);
      chk("R7 flush keeps underflow", int'(unf), 1);
   endtask

   task automatic t_fixed;
      f_enq = 1'b1;
      @(posedge clk); #1;
      f_enq = 1'b0;
      chk("R12 fixed armed", int'(f_armed), 1);
      wait_cyc(50);
      chk("R12 no pulse at edge 50", int'(f_timeout), 0);
      wait_cyc(1);
      chk("R12 pulse at edge 51", int'(f_timeout), 1);
      chk("R12 fixed count", int'(f_count), 1);
      f_flush = 1'b1;
      @(posedge clk); #1;
      f_flush = 1'b0;
      chk("R12 fixed flush", int'(f_count), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      wait_cyc(3);
      t_reset();
      t_arm_expire();
      t_no_restart();
      t_reload();
      t_deq_zero();
      t_both();
      t_flush();
      t_sat();
      t_interval();
      t_fixed();
      t_underflow();
      summary();
      $finish;
   end
endmodule